// File: doc/BRIEF.md
# Timer Compare/Capture Channel

This block pairs a 16-bit up-counter with one channel that either compares or captures. While enabled, the counter steps from zero up to a programmable terminal value and then returns to zero, raising a sticky overflow flag each time it wraps. In compare mode, the channel changes an output pin when the count equals its compare value. The available actions are set, clear and toggle. Two further actions also drive the pin the opposite way each time the count passes zero, which gives a PWM waveform whose period is set by the terminal value and whose duty is set by the compare value.

In capture mode, a rising edge on the capture input is synchronised to the clock. It copies the current count into the compare register. Both a match and a capture set a channel flag, and that flag is gated by a mask bit to form the interrupt request. The hardware sets both flags. Software clears them by writing zero. Registers are reached through a byte-wide write port and a combinational read port.

Register map (byte addresses):
- 0 and 1 hold the terminal value, low byte then high byte. Each write takes effect at once. The reset value is 0xFFFF.
- 2 and 3 hold the compare value, low byte then high byte. A write to 2 is held in a staging byte. A write to 3 loads both bytes together. Reads return the value in force.
- 4 is control: bit 0 is the mode, bits 3:1 the action, bit 4 the interrupt mask and bit 5 the run enable.
- 5 is status: bit 0 is the channel flag and bit 1 the overflow flag.
- 6 and 7 hold the count, low byte then high byte, and are read-only.

Top module: `tcc_top`

## Requirements
- R1: After reset the count, the compare value, both flags and the output pin are 0, the terminal value is 0xFFFF, and the control byte reads 0x10: capture mode, action 000, mask set, stopped.
- R2: While control bit 5 is 1, the count advances by one per clock. When the count is at or above the terminal value, the next value is 0 and the overflow flag (status bit 1) becomes 1. The flag stays at 1 until cleared.
- R3: A write to address 2 leaves the compare value in force unchanged. A following write to address 3 loads {high, staged low} in one step.
- R4: In compare mode (control bit 0 = 1) while running, a count equal to the compare value changes the pin on the next clock: action 000 sets it, 001 clears it and 010 inverts it.
- R5: Action 011 sets the pin on a match and clears it when the count is 0. Action 100 clears it on a match and sets it when the count is 0. When the compare value is 0, the match action wins.
- R6: Actions 101, 110 and 111 leave the pin unchanged.
- R7: In capture mode (control bit 0 = 0), a rising edge on cap_in copies the count into the compare value within four clocks and sets the channel flag.
- R8: A compare match sets the channel flag (status bit 0). The interrupt request equals the channel flag ANDed with control bit 4.
- R9: Writing a 0 to a status bit clears that flag, and writing a 1 has no effect. A hardware set in the same cycle wins over the clear.
- R10: While stopped, or in capture mode, the pin does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Write byte address |
| wr_data | input | 8 | Write data |
| rd_addr | input | 3 | Read byte address |
| rd_data | output | 8 | Read data (combinational) |
| cap_in | input | 1 | Asynchronous capture input |
| out_pin | output | 1 | Compare output |
| chan_flag | output | 1 | Channel event flag |
| ovf_flag | output | 1 | Counter wrap flag |
| chan_irq | output | 1 | Masked channel interrupt request |

## Verification
A bad count or terminal compare shows up as a wrong overflow flag, or as a pin edge one or more clocks early or late. The bench's cycle model catches this on the clock where the two diverge. A wrongly staged compare byte shows up right away on the compare readback, and later as shifted pin edges. A synchroniser or edge detector fault leaves the captured value or the channel flag wrong a few clocks after the capture pulse. A fault in flag clearing shows up on the next status read or interrupt sample.

// File: rtl/tcc_pkg.sv
// Shared types and constants for the timer compare/capture channel.
// Assumes a 16-bit counter reached as two byte registers.
package tcc_pkg;
    localparam int unsigned CNT_W  = 16;
    localparam int unsigned BYTE_W = 8;
    localparam int unsigned ADDR_W = 3;

    typedef enum logic [2:0] {
        ACT_SET      = 3'd0,
        ACT_CLR      = 3'd1,
        ACT_TGL      = 3'd2,
        ACT_SET_ZCLR = 3'd3,
        ACT_CLR_ZSET = 3'd4
    } act_e;

    localparam logic [ADDR_W-1:0] A_TERM_LO = 3'd0;
    localparam logic [ADDR_W-1:0] A_TERM_HI = 3'd1;
    localparam logic [ADDR_W-1:0] A_CMP_LO  = 3'd2;
    localparam logic [ADDR_W-1:0] A_CMP_HI  = 3'd3;
    localparam logic [ADDR_W-1:0] A_CTRL    = 3'd4;
    localparam logic [ADDR_W-1:0] A_STAT    = 3'd5;
    localparam logic [ADDR_W-1:0] A_CNT_LO  = 3'd6;
    localparam logic [ADDR_W-1:0] A_CNT_HI  = 3'd7;
endpackage

// File: rtl/tcc_counter.sv
// Up-counter that wraps to zero at or above the terminal value.
// Assumes the terminal value may change at any time; a count already past
// it wraps on the next enabled clock.
module tcc_counter
    import tcc_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [CNT_W-1:0] term,
    output logic [CNT_W-1:0] cnt,
    output logic             wrap
);
    assign wrap = run && (cnt >= term);

    // Advance or wrap the count while enabled.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (wrap)
            cnt <= '0;
        else if (run)
            cnt <= cnt + 1'b1;
    end

    assert_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (run && cnt >= term) |=> (cnt == '0));
    assert_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (run && cnt < term) |=> (cnt == $past(cnt) + 1'b1));
    assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> $stable(cnt));
endmodule

// File: rtl/tcc_capsync.sv
// Synchronises the asynchronous capture input and detects its rising edge.
// Assumes SYNC_STAGES >= 2; the edge pulse lasts one clock.
module tcc_capsync #(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cap_in,
    output logic rise
);
    logic [SYNC_STAGES-1:0] sync_q;
    logic                   prev_q;

    // First stage samples the raw input.
    always_ff @(posedge clk) begin
        if (!rst_n) sync_q[0] <= 1'b0;
        else        sync_q[0] <= cap_in;
    end

    for (genvar i = 1; i < SYNC_STAGES; i++) begin : g_sync
        // Later stages shift the sample along the chain.
        always_ff @(posedge clk) begin
            if (!rst_n) sync_q[i] <= 1'b0;
            else        sync_q[i] <= sync_q[i-1];
        end
    end

    // Remember the last synchronised level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= sync_q[SYNC_STAGES-1];
    end

    assign rise = sync_q[SYNC_STAGES-1] && !prev_q;

    assert_single_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> !rise);
endmodule

// File: rtl/tcc_cmpout.sv
// Compare logic and output pin register.
// Assumes a match has priority over the zero event when both occur together.
module tcc_cmpout
    import tcc_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             mode,
    input  logic [2:0]       act,
    input  logic [CNT_W-1:0] cnt,
    input  logic [CNT_W-1:0] cmp,
    output logic             out_pin,
    output logic             match_evt
);
    logic zero_evt;
    logic out_nxt;

    assign match_evt = run && mode && (cnt == cmp);
    assign zero_evt  = run && mode && (cnt == '0);

    // Choose the next pin level from the action code.
    always_comb begin
        out_nxt = out_pin;
        if (match_evt) begin
            case (act)
                ACT_SET, ACT_SET_ZCLR: out_nxt = 1'b1;
                ACT_CLR, ACT_CLR_ZSET: out_nxt = 1'b0;
                ACT_TGL:               out_nxt = !out_pin;
                default:               out_nxt = out_pin;
            endcase
        end else if (zero_evt) begin
            case (act)
                ACT_SET_ZCLR: out_nxt = 1'b0;
                ACT_CLR_ZSET: out_nxt = 1'b1;
                default:      out_nxt = out_pin;
            endcase
        end
    end

    // Register the pin.
    always_ff @(posedge clk) begin
        if (!rst_n) out_pin <= 1'b0;
        else        out_pin <= out_nxt;
    end

    assert_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (run && mode && cnt == cmp && act == 3'd0) |=> out_pin);
    assert_tgl_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (run && mode && cnt == cmp && act == 3'd2) |=> (out_pin != $past(out_pin)));
    assert_zero_clr_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (run && mode && cnt == '0 && cmp != '0 && act == 3'd3) |=> !out_pin);
    assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (act >= 3'd5) |=> $stable(out_pin));
    assert_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!run || !mode) |=> $stable(out_pin));
endmodule

// File: rtl/tcc_regs.sv
// Byte-wide register file: terminal value, staged compare value, control,
// and the two sticky flags. Assumes CNT_W is two bytes wide.
module tcc_regs
    import tcc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [BYTE_W-1:0] rd_data,
    input  logic [CNT_W-1:0]  cnt,
    input  logic              cap_load,
    input  logic              chan_set,
    input  logic              ovf_set,
    output logic [CNT_W-1:0]  term,
    output logic [CNT_W-1:0]  cmp,
    output logic              mode,
    output logic [2:0]        act,
    output logic              mask,
    output logic              run,
    output logic              chan_flag,
    output logic              ovf_flag
);
    logic [BYTE_W-1:0] stage_lo;
    logic              wr_stat;

    assign wr_stat = wr_en && (wr_addr == A_STAT);

    // Terminal value bytes take effect immediately.
    always_ff @(posedge clk) begin
        if (!rst_n) term <= '1;
        else if (wr_en && wr_addr == A_TERM_LO) term[BYTE_W-1:0] <= wr_data;
        else if (wr_en && wr_addr == A_TERM_HI) term[CNT_W-1:BYTE_W] <= wr_data;
    end

    // Hold the low compare byte until the high byte arrives.
    always_ff @(posedge clk) begin
        if (!rst_n) stage_lo <= '0;
        else if (wr_en && wr_addr == A_CMP_LO) stage_lo <= wr_data;
    end

    // Compare value: captured count or a committed byte pair.
    always_ff @(posedge clk) begin
        if (!rst_n) cmp <= '0;
        else if (cap_load) cmp <= cnt;
        else if (wr_en && wr_addr == A_CMP_HI) cmp <= {wr_data, stage_lo};
    end

    // Control byte fields.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode <= 1'b0;
            act  <= 3'd0;
            mask <= 1'b1;
            run  <= 1'b0;
        end else if (wr_en && wr_addr == A_CTRL) begin
            mode <= wr_data[0];
            act  <= wr_data[3:1];
            mask <= wr_data[4];
            run  <= wr_data[5];
        end
    end

    // Sticky flags: hardware set beats a software clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chan_flag <= 1'b0;
            ovf_flag  <= 1'b0;
        end else begin
            if (chan_set)                  chan_flag <= 1'b1;
            else if (wr_stat && !wr_data[0]) chan_flag <= 1'b0;
            if (ovf_set)                   ovf_flag <= 1'b1;
            else if (wr_stat && !wr_data[1]) ovf_flag <= 1'b0;
        end
    end

    // Combinational readback.
    always_comb begin
        case (rd_addr)
            A_TERM_LO: rd_data = term[BYTE_W-1:0];
            A_TERM_HI: rd_data = term[CNT_W-1:BYTE_W];
            A_CMP_LO:  rd_data = cmp[BYTE_W-1:0];
            A_CMP_HI:  rd_data = cmp[CNT_W-1:BYTE_W];
            A_CTRL:    rd_data = {2'b00, run, mask, act, mode};
            A_STAT:    rd_data = {6'b0, ovf_flag, chan_flag};
            A_CNT_LO:  rd_data = cnt[BYTE_W-1:0];
            default:   rd_data = cnt[CNT_W-1:BYTE_W];
        endcase
    end

    assert_stage_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == A_CMP_LO && !cap_load) |=> $stable(cmp));
    assert_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (chan_flag && !(wr_stat && !wr_data[0])) |=> chan_flag);
    assert_ovf_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_set |=> ovf_flag);
    assert_cap_R7: assert property (@(posedge clk) disable iff (!rst_n)
        cap_load |=> (cmp == $past(cnt) && chan_flag));
endmodule

// File: rtl/tcc_top.sv
// Timer compare/capture channel top: wires counter, synchroniser,
// compare logic and register file. Assumes cap_in is asynchronous.
module tcc_top
    import tcc_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [BYTE_W-1:0] rd_data,
    input  logic              cap_in,
    output logic              out_pin,
    output logic              chan_flag,
    output logic              ovf_flag,
    output logic              chan_irq
);
    logic [CNT_W-1:0] cnt, term, cmp;
    logic             wrap, rise, cap_load, match_evt;
    logic             mode, mask, run;
    logic [2:0]       act;

    assign cap_load = rise && !mode;

    tcc_counter u_cnt (
        .clk(clk), .rst_n(rst_n), .run(run), .term(term), .cnt(cnt), .wrap(wrap)
    );

    tcc_capsync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .cap_in(cap_in), .rise(rise)
    );

    tcc_cmpout u_cmp (
        .clk(clk), .rst_n(rst_n), .run(run), .mode(mode), .act(act),
        .cnt(cnt), .cmp(cmp), .out_pin(out_pin), .match_evt(match_evt)
    );

    tcc_regs u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .cnt(cnt),
        .cap_load(cap_load), .chan_set(match_evt || cap_load), .ovf_set(wrap),
        .term(term), .cmp(cmp), .mode(mode), .act(act), .mask(mask), .run(run),
        .chan_flag(chan_flag), .ovf_flag(ovf_flag)
    );

    assign chan_irq = chan_flag && mask;

    assert_irq_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (match_evt && mask) |=> chan_irq);
endmodule

// File: tb/tcc_top_test.sv
module tcc_top_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [2:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic [2:0] rd_addr = '0;
    logic [7:0] rd_data;
    logic       cap_in = 1'b0;
    logic       out_pin, chan_flag, ovf_flag, chan_irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    bit mchk = 1'b0;

    // reference model state
    logic [15:0] m_cnt, m_term, m_cmp;
    logic [7:0]  m_stage, m_ctrl;
    logic        m_out, m_cf, m_of;

    always #4 clk = !clk;

    tcc_top uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .cap_in(cap_in), .out_pin(out_pin), .chan_flag(chan_flag),
        .ovf_flag(ovf_flag), .chan_irq(chan_irq)
    );

    function automatic logic next_out(logic cur, logic [2:0] a, logic mt, logic zr);
        if (mt) begin
            case (a)
                3'd0, 3'd3: return 1'b1;
                3'd1, 3'd4: return 1'b0;
                3'd2:       return !cur;
                default:    return cur;
            endcase
        end else if (zr) begin
            if (a == 3'd3) return 1'b0;
            if (a == 3'd4) return 1'b1;
        end
        return cur;
    endfunction

    // cycle model of the requirements (compare mode only)
    always @(posedge clk) begin
        if (!rst_n) begin
            m_cnt <= '0; m_term <= 16'hFFFF; m_cmp <= '0; m_stage <= '0;
            m_ctrl <= 8'h10; m_out <= 1'b0; m_cf <= 1'b0; m_of <= 1'b0;
        end else begin
            automatic logic run = m_ctrl[5];
            automatic logic cm  = m_ctrl[0];
            automatic logic mt  = run && cm && (m_cnt == m_cmp);
            automatic logic zr  = run && cm && (m_cnt == 16'd0);
            automatic logic wp  = run && (m_cnt >= m_term);
            if (wp) m_cnt <= '0; else if (run) m_cnt <= m_cnt + 16'd1;
            m_out <= next_out(m_out, m_ctrl[3:1], mt, zr);
            if (mt) m_cf <= 1'b1;
            else if (wr_en && wr_addr == 3'd5 && !wr_data[0]) m_cf <= 1'b0;
            if (wp) m_of <= 1'b1;
            else if (wr_en && wr_addr == 3'd5 && !wr_data[1]) m_of <= 1'b0;
            if (wr_en) begin
                case (wr_addr)
                    3'd0: m_term[7:0] <= wr_data;
                    3'd1: m_term[15:8] <= wr_data;
                    3'd2: m_stage <= wr_data;
                    3'd3: m_cmp <= {wr_data, m_stage};
                    3'd4: m_ctrl <= wr_data;
                    default: ;
                endcase
            end
        end
    end

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", req, act, exp);
        end
    endtask

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (mchk && rst_n) begin
            chk("R4/R5/R6/R10 pin", int'(out_pin), int'(m_out));
            chk("R8 chan flag", int'(chan_flag), int'(m_cf));
            chk("R2 overflow", int'(ovf_flag), int'(m_of));
        end
    end

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        rd_addr = a;
        #1;
        d = rd_data;
    endtask

    initial begin
        logic [7:0] v, c;
        logic [15:0] t, cv;
        logic [2:0] a;
        logic cm, ovf_before;
        void'($urandom(32'd20240917));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1 pin", int'(out_pin), 0);
        chk("R1 flags", int'({chan_flag, ovf_flag, chan_irq}), 0);
        rd(3'd4, v); chk("R1 ctrl", v, 8'h10);
        rd(3'd0, v); chk("R1 term lo", v, 8'hFF);
        rd(3'd1, v); chk("R1 term hi", v, 8'hFF);
        rd(3'd6, v); chk("R1 count", v, 0);
        rd(3'd2, v); chk("R1 cmp", v, 0);

        // R3 staging
        wr(3'd2, 8'h55);
        rd(3'd2, v); chk("R3 low held", v, 8'h00);
        wr(3'd3, 8'h12);
        rd(3'd2, v); chk("R3 low commit", v, 8'h55);
        rd(3'd3, v); chk("R3 high commit", v, 8'h12);

        // random compare-mode runs against the model
        mchk = 1'b1;
        for (int it = 0; it < 40; it++) begin
            t  = 16'(3 + $urandom_range(0, 37));
            case ($urandom_range(0, 3))
                0: cv = 16'd0;
                1: cv = t;
                default: cv = 16'($urandom_range(0, int'(t)));
            endcase
            a  = 3'($urandom_range(0, 7));
            cm = ($urandom_range(0, 4) != 0);
            wr(3'd0, t[7:0]); wr(3'd1, t[15:8]);
            wr(3'd2, cv[7:0]); wr(3'd3, cv[15:8]);
            wr(3'd4, {2'b00, 1'b1, 1'b1, a, cm});
            repeat (3 * int'(t) + 5) @(negedge clk);
            wr(3'd4, {2'b00, 1'b0, 1'b1, a, cm});
            repeat (4) @(negedge clk);
            rd(3'd6, v); chk("R2 count lo", v, m_cnt[7:0]);
            wr(3'd5, 8'h00);
        end
        mchk = 1'b0;

        // R9 writing 1 does not clear; writing 0 clears one bit only
        wr(3'd0, 8'd5); wr(3'd1, 8'd0);
        wr(3'd2, 8'd2); wr(3'd3, 8'd0);
        wr(3'd4, 8'h31);
        repeat (12) @(negedge clk);
        wr(3'd4, 8'h11);
        chk("R2 ovf sticky", int'(ovf_flag), 1);
        wr(3'd5, 8'h03);
        chk("R9 write 1 keeps chan", int'(chan_flag), 1);
        chk("R9 write 1 keeps ovf", int'(ovf_flag), 1);
        wr(3'd5, 8'h02);
        chk("R9 clear chan", int'(chan_flag), 0);
        chk("R9 ovf untouched", int'(ovf_flag), 1);
        wr(3'd5, 8'h00);
        chk("R9 clear ovf", int'(ovf_flag), 0);

        // R7 capture
        wr(3'd0, 8'd200); wr(3'd1, 8'd0);
        wr(3'd4, 8'h30);
        repeat (23) @(negedge clk);
        wr(3'd4, 8'h10);
        rd(3'd6, c);
        ovf_before = out_pin;
        cap_in = 1'b1;
        repeat (3) @(negedge clk);
        cap_in = 1'b0;
        repeat (4) @(negedge clk);
        rd(3'd2, v); chk("R7 captured lo", v, c);
        rd(3'd3, v); chk("R7 captured hi", v, 0);
        chk("R7 flag", int'(chan_flag), 1);
        chk("R8 irq unmasked", int'(chan_irq), 1);
        chk("R10 pin in capture", int'(out_pin), int'(ovf_before));
        wr(3'd4, 8'h00);
        chk("R8 irq masked", int'(chan_irq), 0);
        chk("R8 flag kept", int'(chan_flag), 1);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual hung expected done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule